// File: doc/BRIEF.md
# Split-Transaction Request-Bus Phase Sequencer

This block owns the address/command half of a split-transaction bus shared by several cache controllers. Any number of clients may raise a request with a command and an address in the same cycle. The block picks one of them, hands it a transaction tag from an external pool of free tags, and then walks the transaction through a fixed series of phases: resolution (grant and tag shown to all clients), address drive, snoop decode and snoop acknowledge. The commit point of the memory operation is the decode slot, which carries no bus traffic for that transaction.

Transactions overlap. While one transaction sits in decode, the next can drive the address bus and a third can be resolving. Any client can hold its snoop-inhibit line high to stretch the acknowledge slot, and that stall backs up through the pipeline, freezing the address bus and blocking new arbitration once every slot is occupied. Because the pipeline never reorders, the grant order is the global order of commits and acknowledges.

Top module: `rsq_request_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, tag_pop_o, grant_o, bus_valid_o, commit_o and ack_done_o are all zero.
- R2: In a cycle with at least one eligible request, tag_avail_i high and the resolution slot free or emptying, tag_pop_o is high; in the next cycle grant_o is one-hot for the chosen client and grant_tag_o equals the tag_free_i value of the arbitration cycle. grant_o is never more than one-hot.
- R3: With tag_avail_i low, tag_pop_o stays low and no new grant appears, whatever the requests.
- R4: Arbitration is round-robin: the winner is the first requesting client found by counting upward (with wrap) from the previous winner; after reset the search starts at client 0.
- R5: In the cycle after resolution (when the address slot accepts it), bus_valid_o is high and bus_src_o, bus_cmd_o, bus_addr_o, bus_tag_o carry the winner's index, its command and address as sampled in the arbitration cycle, and its tag. With bus_valid_o low these outputs are zero.
- R6: commit_o pulses exactly once per transaction, in the last cycle of its decode slot, with commit_tag_o giving the tag; decode follows the address cycle.
- R7: The acknowledge slot follows decode; ack_done_o pulses with ack_tag_o in the first cycle of that slot in which every inhibit_i bit is low. Any inhibit bit high keeps the transaction in acknowledge.
- R8: A stalled acknowledge stalls decode, holds bus_valid_o and the bus fields unchanged, holds the resolution slot and, once all slots are full, blocks tag_pop_o.
- R9: The sequence of commit tags and the sequence of acknowledge tags both equal the sequence of granted tags.
- R10: A client shown on grant_o in a cycle is not eligible in that cycle's arbitration, even if its request line is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_CLI | Per-client request lines |
| cmd_i | input | N_CLI*CMD_W | Per-client commands, client c at bits [c*CMD_W +: CMD_W] |
| addr_i | input | N_CLI*ADDR_W | Per-client addresses, client c at bits [c*ADDR_W +: ADDR_W] |
| tag_avail_i | input | 1 | Free-tag pool is not empty |
| tag_free_i | input | TAG_W | Next free tag offered by the pool |
| inhibit_i | input | N_CLI | Per-client snoop-not-ready lines |
| tag_pop_o | output | 1 | Pool tag consumed this cycle (arbitration accepted) |
| grant_o | output | N_CLI | One-hot grant during resolution |
| grant_tag_o | output | TAG_W | Tag assigned to the granted transaction |
| bus_valid_o | output | 1 | Address/command bus is driven |
| bus_src_o | output | $clog2(N_CLI) | Index of the client owning the bus cycle |
| bus_cmd_o | output | CMD_W | Broadcast command |
| bus_addr_o | output | ADDR_W | Broadcast address |
| bus_tag_o | output | TAG_W | Broadcast tag |
| commit_o | output | 1 | Transaction leaves decode (commit point) |
| commit_tag_o | output | TAG_W | Tag of the transaction in decode |
| ack_done_o | output | 1 | Acknowledge phase completes |
| ack_tag_o | output | TAG_W | Tag of the transaction in acknowledge |

## Verification
A slot whose valid bit is lost or duplicated shows up within one to four cycles as a missing or doubled commit_o or ack_done_o pulse, and the bench's tag-order queues flag it at the first such pulse. A wrong round-robin pointer shows as a wrong grant_o index on the very next grant, and a broken stall path shows as bus_addr_o changing, or tag_pop_o rising, in the first stalled cycle. Payload mis-steering between slots appears as a mismatched bus field or commit tag as soon as the corrupted transaction reaches that slot.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  // Slot indices of the phase pipeline, in the order a transaction visits them
  localparam int ST_RSLV    = 0;
  localparam int ST_ADDR    = 1;
  localparam int ST_DCD     = 2;
  localparam int ST_ACK     = 3;
  localparam int NUM_STAGES = 4;

  localparam int MAX_CLI = 32;

  // Round-robin search: first set bit after position 'last', wrapping modulo n.
  // Returns -1 when no bit is set.
  function automatic int rr_pick(input logic [MAX_CLI-1:0] req, input int last, input int n);
    int res;
    int idx;
    res = -1;
    for (int k = 1; k <= MAX_CLI; k++) begin
      if (k <= n && res < 0) begin
        idx = (last + k) % n;
        if (req[idx]) res = idx;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/rsq_rr_arbiter.sv
module rsq_rr_arbiter
  import rsq_pkg::*;
#(
  parameter int N_CLI = 4,
  localparam int CLI_W = $clog2(N_CLI)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CLI-1:0] req_i,
  input  logic             take_i,
  output logic             any_o,
  output logic [CLI_W-1:0] win_o
);

  logic [CLI_W-1:0] last_q;
  int               pick;

  always_comb begin
    pick  = rr_pick(MAX_CLI'(req_i), int'(last_q), N_CLI);
    any_o = (pick >= 0);
    win_o = any_o ? CLI_W'(pick) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= CLI_W'(N_CLI - 1);
    else if (take_i) last_q <= win_o;
  end

  AST_TAKE_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> any_o); // R2
  AST_WIN_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req_i[win_o]); // R4
  AST_POINTER_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (last_q == $past(win_o))); // R4

endmodule

// File: rtl/rsq_phase_reg.sv
module rsq_phase_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         leave_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      q_o <= '0;
    end else begin
      if (load_i)       v_o <= 1'b1;
      else if (leave_i) v_o <= 1'b0;
      if (load_i)       q_o <= d_i;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!v_o || leave_i)); // R8
  AST_LEAVE_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    leave_i |-> v_o); // R8
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (v_o && !leave_i) |=> (v_o && $stable(q_o))); // R8

endmodule

// File: rtl/rsq_request_sequencer.sv
module rsq_request_sequencer
  import rsq_pkg::*;
#(
  parameter int N_CLI  = 4,
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 3,
  parameter int TAG_W  = 3,
  localparam int CLI_W = $clog2(N_CLI)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CLI-1:0]        req_i,
  input  logic [N_CLI*CMD_W-1:0]  cmd_i,
  input  logic [N_CLI*ADDR_W-1:0] addr_i,
  input  logic                    tag_avail_i,
  input  logic [TAG_W-1:0]        tag_free_i,
  input  logic [N_CLI-1:0]        inhibit_i,
  output logic                    tag_pop_o,
  output logic [N_CLI-1:0]        grant_o,
  output logic [TAG_W-1:0]        grant_tag_o,
  output logic                    bus_valid_o,
  output logic [CLI_W-1:0]        bus_src_o,
  output logic [CMD_W-1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  output logic [TAG_W-1:0]        bus_tag_o,
  output logic                    commit_o,
  output logic [TAG_W-1:0]        commit_tag_o,
  output logic                    ack_done_o,
  output logic [TAG_W-1:0]        ack_tag_o
);

  localparam int PW = CLI_W + TAG_W + CMD_W + ADDR_W;

  // Payload layout helpers: {src, tag, cmd, addr}
  function automatic logic [CLI_W-1:0] pl_src(input logic [PW-1:0] p);
    return p[PW-1 -: CLI_W];
  endfunction
  function automatic logic [TAG_W-1:0] pl_tag(input logic [PW-1:0] p);
    return p[ADDR_W+CMD_W +: TAG_W];
  endfunction
  function automatic logic [CMD_W-1:0] pl_cmd(input logic [PW-1:0] p);
    return p[ADDR_W +: CMD_W];
  endfunction
  function automatic logic [ADDR_W-1:0] pl_addr(input logic [PW-1:0] p);
    return p[ADDR_W-1:0];
  endfunction

  // Named internal events
  logic                  snoop_wait;
  logic [N_CLI-1:0]      eligible;
  logic                  arb_any;
  logic [CLI_W-1:0]      arb_win;
  logic                  arb_accept;
  logic [PW-1:0]         new_pl;

  logic [NUM_STAGES-1:0] st_v;
  logic [NUM_STAGES-1:0] st_load;
  logic [NUM_STAGES-1:0] st_leave;
  logic [NUM_STAGES-1:0] st_go;
  logic [NUM_STAGES-1:0] st_free;
  logic [PW-1:0]         st_d [NUM_STAGES];
  logic [PW-1:0]         st_q [NUM_STAGES];

  assign snoop_wait = |inhibit_i;

  // A client being shown its grant must not win again in the same cycle
  assign eligible = req_i & ~grant_o;

  rsq_rr_arbiter #(.N_CLI(N_CLI)) i_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (eligible),
    .take_i (arb_accept),
    .any_o  (arb_any),
    .win_o  (arb_win)
  );

  assign arb_accept = arb_any & tag_avail_i & st_free[ST_RSLV];
  assign new_pl     = {arb_win, tag_free_i,
                       cmd_i[arb_win*CMD_W +: CMD_W],
                       addr_i[arb_win*ADDR_W +: ADDR_W]};

  // Phase slots with a backward ready chain from the acknowledge slot
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_slot
    if (k == NUM_STAGES-1) begin : g_tail
      assign st_go[k] = ~snoop_wait;
    end else begin : g_mid
      assign st_go[k] = st_free[k+1];
    end
    assign st_free[k]  = ~st_v[k] | st_go[k];
    assign st_leave[k] = st_v[k] & st_go[k];
    if (k == 0) begin : g_head
      assign st_load[k] = arb_accept;
      assign st_d[k]    = new_pl;
    end else begin : g_body
      assign st_load[k] = st_leave[k-1];
      assign st_d[k]    = st_q[k-1];
    end
    rsq_phase_reg #(.W(PW)) i_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (st_load[k]),
      .leave_i (st_leave[k]),
      .d_i     (st_d[k]),
      .v_o     (st_v[k]),
      .q_o     (st_q[k])
    );
  end

  // Output decode per phase
  always_comb begin
    tag_pop_o = arb_accept;

    grant_o     = '0;
    grant_tag_o = '0;
    if (st_v[ST_RSLV]) begin
      grant_o[pl_src(st_q[ST_RSLV])] = 1'b1;
      grant_tag_o = pl_tag(st_q[ST_RSLV]);
    end

    bus_valid_o = st_v[ST_ADDR];
    bus_src_o   = st_v[ST_ADDR] ? pl_src(st_q[ST_ADDR])  : '0;
    bus_cmd_o   = st_v[ST_ADDR] ? pl_cmd(st_q[ST_ADDR])  : '0;
    bus_addr_o  = st_v[ST_ADDR] ? pl_addr(st_q[ST_ADDR]) : '0;
    bus_tag_o   = st_v[ST_ADDR] ? pl_tag(st_q[ST_ADDR])  : '0;

    commit_o     = st_leave[ST_DCD];
    commit_tag_o = st_v[ST_DCD] ? pl_tag(st_q[ST_DCD]) : '0;

    ack_done_o = st_leave[ST_ACK];
    ack_tag_o  = st_v[ST_ACK] ? pl_tag(st_q[ST_ACK]) : '0;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R2
  AST_POP_THEN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    tag_pop_o |=> (grant_o != '0 && grant_tag_o == $past(tag_free_i))); // R2
  AST_NO_TAG_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_avail_i |-> !tag_pop_o); // R3
  AST_BUS_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v[ST_RSLV] && st_leave[ST_RSLV]) |=> bus_valid_o); // R5
  AST_ACK_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v[ST_ACK] && snoop_wait) |=> (st_v[ST_ACK] && $stable(ack_tag_o))); // R7
  AST_BUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !st_leave[ST_ADDR]) |=>
      (bus_valid_o && $stable(bus_addr_o) && $stable(bus_tag_o))); // R8
  AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    tag_pop_o |-> !grant_o[arb_win]); // R10

endmodule

// File: tb/test_rsq_request_sequencer.sv
module test_rsq_request_sequencer;
  localparam int N   = 4;
  localparam int AW  = 32;
  localparam int CW  = 3;
  localparam int TW  = 3;
  localparam int CLW = 2;
  localparam int NT  = 1 << TW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N*CW-1:0] cmd = '0;
  logic [N*AW-1:0] addr = '0;
  logic            tag_avail = 1'b0;
  logic [TW-1:0]   tag_free = '0;
  logic [N-1:0]    inhibit = '0;

  logic            tag_pop, bus_valid, commit, ack_done;
  logic [N-1:0]    grant;
  logic [TW-1:0]   grant_tag, bus_tag, commit_tag, ack_tag;
  logic [CLW-1:0]  bus_src;
  logic [CW-1:0]   bus_cmd;
  logic [AW-1:0]   bus_addr;

  always #10 clk = ~clk;

  rsq_request_sequencer #(.N_CLI(N), .ADDR_W(AW), .CMD_W(CW), .TAG_W(TW)) i_rsq_request_sequencer (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cmd_i(cmd), .addr_i(addr),
    .tag_avail_i(tag_avail), .tag_free_i(tag_free), .inhibit_i(inhibit),
    .tag_pop_o(tag_pop), .grant_o(grant), .grant_tag_o(grant_tag),
    .bus_valid_o(bus_valid), .bus_src_o(bus_src), .bus_cmd_o(bus_cmd),
    .bus_addr_o(bus_addr), .bus_tag_o(bus_tag), .commit_o(commit),
    .commit_tag_o(commit_tag), .ack_done_o(ack_done), .ack_tag_o(ack_tag)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Reference state, built from the requirements
  bit             mv    [4];
  logic [CLW-1:0] msrc  [4];
  logic [TW-1:0]  mtag  [4];
  logic [CW-1:0]  mcmd  [4];
  logic [AW-1:0]  maddr [4];
  int             mlast = N-1;
  bit             used  [NT];
  logic [TW-1:0]  q_commit [$];
  logic [TW-1:0]  q_ack    [$];

  // Stimulus controls
  bit           rand_on = 0, all_req = 0, block_force = 0;
  logic [N-1:0] inh_force = '0;
  logic [N-1:0] g_seen = '0;

  // Samples of the last negedge
  logic [N-1:0] s_grant;
  logic         s_pop, s_bus_valid, s_ack_done;
  logic [AW-1:0] s_bus_addr;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int rr_ref(input logic [N-1:0] el, input int last);
    for (int k = 1; k <= N; k++) begin
      if (el[(last + k) % N]) return (last + k) % N;
    end
    return -1;
  endfunction

  function automatic int idx_of(input logic [N-1:0] oh);
    for (int c = 0; c < N; c++) if (oh[c]) return c;
    return -1;
  endfunction

  task automatic check_and_model();
    bit fr [5];
    bit gv [4];
    bit inh, acc, ld, nv;
    logic [N-1:0] gexp, el;
    int w;
    inh = |inhibit;
    fr[4] = 1'b1;
    for (int k = 3; k >= 0; k--) begin
      gv[k] = (k == 3) ? !inh : fr[k+1];
      fr[k] = !mv[k] || gv[k];
    end
    gexp = '0;
    if (mv[0]) gexp[msrc[0]] = 1'b1;
    el  = req & ~gexp;                      // R10: granted client masked
    w   = rr_ref(el, mlast);
    acc = (w >= 0) && tag_avail && fr[0];

    chk(tag_pop == acc, "R2 pop", 64'(tag_pop), 64'(acc));
    chk(grant == gexp && grant_tag == (mv[0] ? mtag[0] : '0), "R2 grant",
        {grant, grant_tag}, {gexp, (mv[0] ? mtag[0] : TW'(0))});
    chk(bus_valid == mv[1] && bus_src == (mv[1] ? msrc[1] : '0) &&
        bus_cmd == (mv[1] ? mcmd[1] : '0) && bus_addr == (mv[1] ? maddr[1] : '0) &&
        bus_tag == (mv[1] ? mtag[1] : '0), "R5 bus",
        {bus_valid, bus_tag, bus_addr}, {mv[1], (mv[1] ? mtag[1] : TW'(0)), (mv[1] ? maddr[1] : AW'(0))});
    chk(commit == (mv[2] && fr[3]) && commit_tag == (mv[2] ? mtag[2] : '0), "R6 commit",
        {commit, commit_tag}, {(mv[2] && fr[3]), (mv[2] ? mtag[2] : TW'(0))});
    chk(ack_done == (mv[3] && !inh) && ack_tag == (mv[3] ? mtag[3] : '0), "R7 ack",
        {ack_done, ack_tag}, {(mv[3] && !inh), (mv[3] ? mtag[3] : TW'(0))});

    if (commit) begin
      if (q_commit.size() == 0) chk(1'b0, "R9 commit order", 64'(commit_tag), 64'hx);
      else begin
        chk(commit_tag == q_commit[0], "R9 commit order", 64'(commit_tag), 64'(q_commit[0]));
        void'(q_commit.pop_front());
      end
    end
    if (ack_done) begin
      if (q_ack.size() == 0) chk(1'b0, "R9 ack order", 64'(ack_tag), 64'hx);
      else begin
        chk(ack_tag == q_ack[0], "R9 ack order", 64'(ack_tag), 64'(q_ack[0]));
        void'(q_ack.pop_front());
      end
    end

    s_grant = grant; s_pop = tag_pop; s_bus_valid = bus_valid;
    s_bus_addr = bus_addr; s_ack_done = ack_done;
    g_seen = grant;

    if (mv[3] && !inh) used[mtag[3]] = 1'b0;
    for (int k = 3; k >= 0; k--) begin
      ld = (k == 0) ? acc : (mv[k-1] && fr[k]);
      nv = ld ? 1'b1 : (mv[k] && !gv[k]);
      if (ld) begin
        if (k == 0) begin
          msrc[0] = CLW'(w); mtag[0] = tag_free;
          mcmd[0] = cmd[w*CW +: CW]; maddr[0] = addr[w*AW +: AW];
        end else begin
          msrc[k] = msrc[k-1]; mtag[k] = mtag[k-1];
          mcmd[k] = mcmd[k-1]; maddr[k] = maddr[k-1];
        end
      end
      mv[k] = nv;
    end
    if (acc) begin
      used[tag_free] = 1'b1;
      q_commit.push_back(tag_free);
      q_ack.push_back(tag_free);
      mlast = w;
    end
  endtask

  task automatic drive();
    bit found;
    for (int c = 0; c < N; c++) if (g_seen[c]) req[c] = 1'b0;
    for (int c = 0; c < N; c++) begin
      if (!req[c] && (all_req || (rand_on && ($urandom % 3) == 0))) begin
        req[c] = 1'b1;
        cmd[c*CW +: CW]  = CW'($urandom);
        addr[c*AW +: AW] = $urandom;
      end
    end
    inhibit = inh_force | ((rand_on && ($urandom % 6) == 0) ? N'($urandom) : '0);
    found = 1'b0;
    tag_free = '0;
    for (int t = 0; t < NT; t++) begin
      if (!found && !used[t]) begin found = 1'b1; tag_free = TW'(t); end
    end
    tag_avail = found && !block_force && !(rand_on && ($urandom % 12) == 0);
  endtask

  task automatic cycle();
    @(negedge clk);
    if (rst_n) check_and_model();
    @(posedge clk);
    #1;
    if (rst_n) drive();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int g [4];
    logic [AW-1:0] a0;
    void'($urandom(32'd1234));
    for (int t = 0; t < NT; t++) used[t] = 1'b0;
    for (int k = 0; k < 4; k++) mv[k] = 1'b0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(!tag_pop && grant == '0 && !bus_valid && !commit && !ack_done, "R1 reset",
          {tag_pop, grant, bus_valid, commit, ack_done}, 64'h0);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tag_pop && grant == '0 && !bus_valid && !commit && !ack_done, "R1 after reset",
        {tag_pop, grant, bus_valid, commit, ack_done}, 64'h0);
    @(posedge clk); #1;

    // R4 / R10: all clients request at once right after reset
    all_req = 1'b1;
    drive();
    cycle();
    for (int i = 0; i < 4; i++) begin
      cycle();
      g[i] = idx_of(s_grant);
    end
    chk(g[0] == 0, "R4 first winner", 64'(g[0]), 64'd0);
    for (int i = 1; i < 4; i++)
      chk(g[i] == (g[i-1] + 1) % N, "R4 rotation", 64'(g[i]), 64'((g[i-1] + 1) % N));
    chk(g[1] != g[0], "R10 no regrant", 64'(g[1]), 64'(g[0]));

    // R8: stall the acknowledge slot with a full pipeline
    repeat (4) cycle();
    inh_force = 4'b0010;
    cycle();
    cycle();
    a0 = s_bus_addr;
    for (int i = 0; i < 3; i++) begin
      cycle();
      chk(s_bus_valid && s_bus_addr == a0, "R8 bus held", 64'(s_bus_addr), 64'(a0));
      chk(!s_ack_done, "R7 inhibit stretch", 64'(s_ack_done), 64'd0);
      chk(!s_pop, "R8 arbitration blocked", 64'(s_pop), 64'd0);
    end
    inh_force = '0;

    // Drain, then R3: no tag means no grant
    all_req = 1'b0;
    req = '0;
    repeat (10) cycle();
    block_force = 1'b1;
    all_req = 1'b1;
    cycle();
    for (int i = 0; i < 4; i++) begin
      cycle();
      chk(!s_pop && s_grant == '0, "R3 no tag", {s_pop, s_grant}, 64'h0);
    end
    block_force = 1'b0;
    all_req = 1'b0;

    // Constrained random traffic with inhibits and tag starvation
    rand_on = 1'b1;
    repeat (2500) cycle();
    rand_on = 1'b0;
    req = '0;
    repeat (12) cycle();
    chk(q_commit.size() == 0 && q_ack.size() == 0, "R9 all retired",
        64'(q_commit.size() + q_ack.size()), 64'd0);

    summary();
    $finish;
  end

endmodule